// File: doc/BRIEF.md
# E1 Multiframe Si/Sa Bit Capture

This block sits behind the framer of an E1 receiver that has already found frame and CRC-4 multiframe alignment. For every timeslot 0 byte it receives a one-cycle strobe, the byte itself, the frame number inside the multiframe, a start marker on frame 0, and a loss-of-multiframe-alignment level. Across one 16-frame multiframe it gathers the international bit of the align frames, and the international bit, the remote alarm bit and the five spare national bits (Sa4 to Sa8) of the non-align frames. Each group fills one byte-wide register, with the earliest frame in the most significant bit.

Bits collect in shadow shift registers. The complete set of eight is copied into the host-visible registers in a single clock after the last frame of the multiframe has been accepted. The host therefore has a whole multiframe (2 ms) to read a consistent set. A sticky ready flag announces each publication and is cleared by a write-one-to-clear strobe. A publication that finds the ready flag still set raises a sticky overrun flag.

A three-state controller drives the capture:
- HUNT waits for a clean frame 0. It moves to GATHER on a frame 0 strobe that carries the start marker while alignment is not lost.
- GATHER accepts strobes whose frame number is the next one expected. The frame 15 strobe takes it to COMMIT. Loss of alignment, or a strobe with an unexpected frame number, sends it back to HUNT. A fresh frame 0 with the start marker restarts GATHER.
- COMMIT lasts one cycle. It publishes unless alignment is lost in that cycle, then behaves like HUNT.

Top module: `ts0_overhead_capture`

## Requirements
- R1: After reset all eight visible registers read 0x00, and the ready and overrun flags are 0.
- R2: A publication happens only after strobes for frames 0 to 15 have been accepted in order, starting with a frame 0 that carries the start marker. It takes effect on the clock edge that follows the cycle after the frame 15 strobe, so the new values and the ready flag are visible from then on.
- R3: The visible registers change only at a publication, and all eight change together on the same clock edge.
- R4: Bit extraction uses ts0_byte bit 7 as the first bit on the line. In even frames the Si bit is ts0_byte[7], and ts0_byte[6:0] are ignored. In odd frames the Si bit is ts0_byte[7], the remote alarm bit is ts0_byte[5], and Sa4 to Sa8 are ts0_byte[4] down to ts0_byte[0]. ts0_byte[6] is ignored in odd frames.
- R5: In the align-frame Si register, frame 2k lands in bit 7-k. In the non-align Si, alarm and Sa registers, frame 2k+1 lands in bit 7-k.
- R6: mf_ready is set by each publication and stays set until a host_clr_wr with host_clr_mask[0]=1. A publication in the same cycle as that clear keeps it set.
- R7: mf_overrun is set when a publication occurs while mf_ready is 1 and is not being cleared in that cycle. It is cleared by host_clr_wr with host_clr_mask[1]=1. A set in the same cycle wins over the clear.
- R8: mf_lost high in any cycle abandons the multiframe being gathered and suppresses a publication pending in that cycle. Gathering resumes only at a frame 0 strobe that carries the start marker.
- R9: In GATHER, a strobe whose frame number is not the expected one abandons the multiframe without publishing. A frame 0 strobe with the start marker restarts gathering from that frame.
- R10: Register addresses are fixed as follows: 0 to 4 hold Sa4 to Sa8, 5 holds the remote alarm bits, 6 holds the align-frame Si bits, and 7 holds the non-align-frame Si bits. rd_data shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts0_valid | input | 1 | One-cycle strobe for a timeslot 0 byte |
| ts0_byte | input | 8 | Timeslot 0 byte; bit 7 is the first bit on the line |
| frame_idx | input | 4 | Frame number within the multiframe (0 to 15) |
| mf_start | input | 1 | Marks the frame 0 strobe of a multiframe |
| mf_lost | input | 1 | Multiframe alignment lost |
| rd_addr | input | 3 | Host register select |
| rd_data | output | 8 | Selected visible register |
| host_clr_wr | input | 1 | Host write-one-to-clear strobe for the flags |
| host_clr_mask | input | 2 | Bit 0 clears ready, bit 1 clears overrun |
| mf_ready | output | 1 | Sticky multiframe-published flag |
| mf_overrun | output | 1 | Sticky flag for a publication over unread data |

## Verification
The bench builds the block with the default MF_FRAMES of 16, which gives a 4-bit frame number and 8-bit registers. This is the only size at which the fixed bit layout of timeslot 0 applies. At this size the bench can drive every frame position, including the wrap from frame 15 to the single-cycle COMMIT state. It can also exercise loss of alignment in the middle of a multiframe and exactly in the COMMIT cycle, skipped frames, restarts at frame 0, and publication and clear landing on the same edge. A behavioural model rebuilds each register from the stored bytes of the frames and is compared with all addresses on every clock.

// File: rtl/ts0_cap_pkg.sv
package ts0_cap_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_GATHER = 2'd1,
        ST_COMMIT = 2'd2
    } cap_state_e;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_SA    = 5;
    localparam int unsigned NUM_REGS  = NUM_SA + 3;
    localparam int unsigned ADDR_W    = $clog2(NUM_REGS);

    // visible register slots (host address map)
    localparam int unsigned REG_ALARM       = NUM_SA;
    localparam int unsigned REG_SI_ALIGN    = NUM_SA + 1;
    localparam int unsigned REG_SI_NONALIGN = NUM_SA + 2;

    // source bit inside the timeslot 0 byte (bit 7 = first on the line)
    localparam int unsigned POS_SI    = 7;
    localparam int unsigned POS_ALARM = 5;
    localparam int unsigned POS_SA4   = 4;

    function automatic int unsigned lane_src(input int unsigned g);
        if (g < NUM_SA)          return POS_SA4 - g;
        else if (g == REG_ALARM) return POS_ALARM;
        else                     return POS_SI;
    endfunction

    function automatic logic lane_is_odd(input int unsigned g);
        return g != REG_SI_ALIGN;
    endfunction

endpackage

// File: rtl/ts0_cap_seq.sv
module ts0_cap_seq
    import ts0_cap_pkg::*;
#(
    parameter int unsigned MF_FRAMES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ts0_valid,
    input  logic [$clog2(MF_FRAMES)-1:0] frame_idx,
    input  logic                         mf_start,
    input  logic                         mf_lost,
    output logic                         take_even,
    output logic                         take_odd,
    output logic                         commit
);

    localparam int unsigned IDX_W = $clog2(MF_FRAMES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MF_FRAMES - 1);

    cap_state_e       state_q, state_d;
    logic [IDX_W-1:0] exp_q;
    logic             start_ok;
    logic             in_seq;
    logic             take;

    assign start_ok = ts0_valid && mf_start && !mf_lost && (frame_idx == '0);
    assign in_seq   = ts0_valid && !mf_lost && (frame_idx == exp_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT, ST_COMMIT: begin
                state_d = start_ok ? ST_GATHER : ST_HUNT;
            end
            ST_GATHER: begin
                if (mf_lost)        state_d = ST_HUNT;
                else if (start_ok)  state_d = ST_GATHER;
                else if (in_seq)    state_d = (exp_q == LAST_IDX) ? ST_COMMIT : ST_GATHER;
                else if (ts0_valid) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        take   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_HUNT:   take = start_ok;
            ST_GATHER: take = start_ok || in_seq;
            ST_COMMIT: begin
                take   = start_ok;
                commit = !mf_lost;
            end
            default: take = 1'b0;
        endcase
    end

    assign take_even = take && !frame_idx[0];
    assign take_odd  = take &&  frame_idx[0];

    // next expected frame number
    always_ff @(posedge clk) begin
        if (!rst_n)    exp_q <= '0;
        else if (take) exp_q <= frame_idx + 1'b1;
    end

endmodule

// File: rtl/ts0_cap_shadow.sv
module ts0_cap_shadow
    import ts0_cap_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               take_even,
    input  logic                               take_odd,
    input  logic [BYTE_W-1:0]                  ts0_byte,
    output logic [NUM_REGS-1:0][REG_W-1:0]     shadow
);

    logic [NUM_REGS-1:0][REG_W-1:0] sh_q;
    logic [NUM_REGS-1:0]            lane_en;

    always_comb begin
        for (int unsigned g = 0; g < NUM_REGS; g++) begin
            lane_en[g] = lane_is_odd(g) ? take_odd : take_even;
        end
    end

    // earliest frame ends up in the MSB after REG_W shifts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            for (int unsigned g = 0; g < NUM_REGS; g++) begin
                if (lane_en[g]) begin
                    sh_q[g] <= {sh_q[g][REG_W-2:0], ts0_byte[3'(lane_src(g))]};
                end
            end
        end
    end

    assign shadow = sh_q;

endmodule

// File: rtl/ts0_cap_regs.sv
module ts0_cap_regs
    import ts0_cap_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [NUM_REGS-1:0][REG_W-1:0] shadow,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [REG_W-1:0]               rd_data,
    input  logic                           host_clr_wr,
    input  logic [1:0]                     host_clr_mask,
    output logic                           mf_ready,
    output logic                           mf_overrun
);

    logic [REG_W-1:0] vis_q [NUM_REGS];
    logic             ready_q;
    logic             ovr_q;
    logic             clr_rdy;
    logic             clr_ovr;

    assign clr_rdy = host_clr_wr && host_clr_mask[0];
    assign clr_ovr = host_clr_wr && host_clr_mask[1];

    // all slots copied on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned g = 0; g < NUM_REGS; g++) vis_q[g] <= '0;
        end else if (commit) begin
            for (int unsigned g = 0; g < NUM_REGS; g++) vis_q[g] <= shadow[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (commit)       ready_q <= 1'b1;
            else if (clr_rdy) ready_q <= 1'b0;

            if (commit && ready_q && !clr_rdy) ovr_q <= 1'b1;
            else if (clr_ovr)                  ovr_q <= 1'b0;
        end
    end

    assign rd_data    = vis_q[rd_addr];
    assign mf_ready   = ready_q;
    assign mf_overrun = ovr_q;

endmodule

// File: rtl/ts0_overhead_capture.sv
module ts0_overhead_capture
    import ts0_cap_pkg::*;
#(
    parameter int unsigned MF_FRAMES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ts0_valid,
    input  logic [7:0]                   ts0_byte,
    input  logic [$clog2(MF_FRAMES)-1:0] frame_idx,
    input  logic                         mf_start,
    input  logic                         mf_lost,
    input  logic [2:0]                   rd_addr,
    output logic [MF_FRAMES/2-1:0]       rd_data,
    input  logic                         host_clr_wr,
    input  logic [1:0]                   host_clr_mask,
    output logic                         mf_ready,
    output logic                         mf_overrun
);

    localparam int unsigned REG_W = MF_FRAMES / 2;

    logic                           take_even;
    logic                           take_odd;
    logic                           commit_pulse;
    logic [NUM_REGS-1:0][REG_W-1:0] shadow;

    ts0_cap_seq #(.MF_FRAMES(MF_FRAMES)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ts0_valid (ts0_valid),
        .frame_idx (frame_idx),
        .mf_start  (mf_start),
        .mf_lost   (mf_lost),
        .take_even (take_even),
        .take_odd  (take_odd),
        .commit    (commit_pulse)
    );

    ts0_cap_shadow #(.REG_W(REG_W)) i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_even (take_even),
        .take_odd  (take_odd),
        .ts0_byte  (ts0_byte),
        .shadow    (shadow)
    );

    ts0_cap_regs #(.REG_W(REG_W)) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit        (commit_pulse),
        .shadow        (shadow),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .host_clr_wr   (host_clr_wr),
        .host_clr_mask (host_clr_mask),
        .mf_ready      (mf_ready),
        .mf_overrun    (mf_overrun)
    );

endmodule

// File: rtl/ts0_cap_checker.sv
module ts0_cap_checker #(
    parameter int unsigned MF_FRAMES = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ts0_valid,
    input logic [$clog2(MF_FRAMES)-1:0] frame_idx,
    input logic                         mf_lost,
    input logic [2:0]                   rd_addr,
    input logic [MF_FRAMES/2-1:0]       rd_data,
    input logic                         host_clr_wr,
    input logic [1:0]                   host_clr_mask,
    input logic                         mf_ready,
    input logic                         mf_overrun,
    input logic                         commit
);

    localparam int unsigned IDX_W = $clog2(MF_FRAMES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MF_FRAMES - 1);

    AST_PUB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(ts0_valid && frame_idx == LAST_IDX)); // R2

    AST_VIS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (!$stable(rd_addr) || $stable(rd_data))); // R3

    AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> mf_ready); // R6

    AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_ready && !commit && !(host_clr_wr && host_clr_mask[0])) |=> mf_ready); // R6

    AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && host_clr_wr && host_clr_mask[0]) |=> !mf_ready); // R6

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mf_ready && !(host_clr_wr && host_clr_mask[0])) |=> mf_overrun); // R7

    AST_LOST_NO_PUB: assert property (@(posedge clk) disable iff (!rst_n)
        mf_lost |=> !commit); // R8

endmodule

bind ts0_overhead_capture ts0_cap_checker #(.MF_FRAMES(MF_FRAMES)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ts0_valid     (ts0_valid),
    .frame_idx     (frame_idx),
    .mf_lost       (mf_lost),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .host_clr_wr   (host_clr_wr),
    .host_clr_mask (host_clr_mask),
    .mf_ready      (mf_ready),
    .mf_overrun    (mf_overrun),
    .commit        (commit_pulse)
);

// File: tb/test_ts0_overhead_capture.sv
`timescale 1ns/1ps
module test_ts0_overhead_capture;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ts0_valid = 1'b0;
    logic [7:0] ts0_byte = '0;
    logic [3:0] frame_idx = '0;
    logic       mf_start = 1'b0;
    logic       mf_lost = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       host_clr_wr = 1'b0;
    logic [1:0] host_clr_mask = '0;
    logic       mf_ready;
    logic       mf_overrun;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  sweep = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ts0_overhead_capture i_ts0_overhead_capture (
        .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_byte(ts0_byte),
        .frame_idx(frame_idx), .mf_start(mf_start), .mf_lost(mf_lost),
        .rd_addr(rd_addr), .rd_data(rd_data), .host_clr_wr(host_clr_wr),
        .host_clr_mask(host_clr_mask), .mf_ready(mf_ready), .mf_overrun(mf_overrun)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_frm [16];
    logic [7:0] m_vis [8];
    bit         m_on, m_pend, m_rdy, m_ovr;
    int         m_exp;

    task automatic publish();
        for (int r = 0; r < 8; r++) m_vis[r] = 8'h00;
        for (int f = 0; f < 16; f++) begin
            int bp = 7 - f / 2;
            if (f % 2 == 0) begin
                m_vis[6][bp] = m_frm[f][7];
            end else begin
                m_vis[7][bp] = m_frm[f][7];
                m_vis[5][bp] = m_frm[f][5];
                for (int j = 0; j < 5; j++) m_vis[j][bp] = m_frm[f][4-j];
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_pend = 0; m_rdy = 0; m_ovr = 0; m_exp = 0;
            for (int r = 0; r < 8; r++) m_vis[r] = 8'h00;
        end else begin
            bit pub, crdy, covr, start, nrdy, novr;
            pub   = m_pend && !mf_lost;
            crdy  = host_clr_wr && host_clr_mask[0];
            covr  = host_clr_wr && host_clr_mask[1];
            start = ts0_valid && mf_start && !mf_lost && frame_idx == 0;
            nrdy = m_rdy; novr = m_ovr;
            if (covr) novr = 0;
            if (pub) begin
                publish();
                if (m_rdy && !crdy) novr = 1;
                nrdy = 1;
            end else if (crdy) nrdy = 0;
            m_rdy = nrdy; m_ovr = novr;
            m_pend = 0;
            if (!m_on) begin
                if (start) begin m_on = 1; m_frm[0] = ts0_byte; m_exp = 1; end
            end else if (mf_lost) begin
                m_on = 0;
            end else if (ts0_valid) begin
                if (start) begin
                    m_frm[0] = ts0_byte; m_exp = 1;
                end else if (int'(frame_idx) == m_exp) begin
                    m_frm[m_exp] = ts0_byte;
                    if (m_exp == 15) begin m_on = 0; m_pend = 1; end
                    else m_exp++;
                end else begin
                    m_on = 0;
                end
            end
        end
    end

    // every-clock comparison
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            n_chk += 3;
            if (sweep && rd_data !== m_vis[rd_addr]) begin
                n_fail++;
                $display("FAIL R3 addr %0d rd_data act %h exp %h", rd_addr, rd_data, m_vis[rd_addr]);
            end
            if (mf_ready !== m_rdy) begin
                n_fail++;
                $display("FAIL R6 mf_ready act %b exp %b", mf_ready, m_rdy);
            end
            if (mf_overrun !== m_ovr) begin
                n_fail++;
                $display("FAIL R7 mf_overrun act %b exp %b", mf_overrun, m_ovr);
            end
        end
    end

    always @(negedge clk) if (sweep) rd_addr = rd_addr + 3'd1;

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_addr = 3'(a);
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic send_frame(input int f, input logic [7:0] b, input bit ms, input bit lost_after);
        @(negedge clk);
        ts0_valid = 1; frame_idx = 4'(f); ts0_byte = b; mf_start = ms;
        @(negedge clk);
        ts0_valid = 0; mf_start = 0; mf_lost = lost_after;
        @(negedge clk);
        mf_lost = 0;
    endtask

    task automatic send_range(input int lo, input int hi);
        for (int f = lo; f <= hi; f++) send_frame(f, 8'($urandom), f == 0, 0);
    endtask

    task automatic host_clear(input logic [1:0] m);
        @(negedge clk);
        host_clr_wr = 1; host_clr_mask = m;
        @(negedge clk);
        host_clr_wr = 0; host_clr_mask = 0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values at every address (R10 map)
        for (int a = 0; a < 8; a++) read_chk(a, 8'h00, "R1 reset register");
        chk("R1 reset ready", 32'(mf_ready), 0);
        chk("R1 reset overrun", 32'(mf_overrun), 0);

        // R4/R5/R10: marker pattern with ignored bits set
        for (int f = 0; f < 16; f++) begin
            logic [7:0] b;
            if (f % 2 == 0) b = (f == 0) ? 8'hFF : 8'h7F;
            else begin
                b = 8'h40;
                if (f == 1)  b |= 8'h80;
                if (f == 3)  b |= 8'h20;
                if (f == 5)  b |= 8'h10;
                if (f == 15) b |= 8'h01;
            end
            if (f == 15) chk("R2 no ready before frame 15", 32'(mf_ready), 0);
            send_frame(f, b, f == 0, 0);
        end
        chk("R2 ready after multiframe", 32'(mf_ready), 1);
        read_chk(0, 8'h20, "R4 R5 R10 Sa4 frame5 bit5");
        read_chk(1, 8'h00, "R4 R10 Sa5");
        read_chk(2, 8'h00, "R4 R10 Sa6");
        read_chk(3, 8'h00, "R4 R10 Sa7");
        read_chk(4, 8'h01, "R4 R5 R10 Sa8 frame15 bit0");
        read_chk(5, 8'h40, "R4 R5 R10 alarm frame3 bit6");
        read_chk(6, 8'h80, "R4 R5 R10 align Si frame0 bit7");
        read_chk(7, 8'h80, "R4 R5 R10 nonalign Si frame1 bit7");

        sweep = 1;
        host_clear(2'b01);
        chk("R6 ready cleared", 32'(mf_ready), 0);

        // R7: two publications without clearing
        send_range(0, 15);
        send_range(0, 15);
        chk("R7 overrun set", 32'(mf_overrun), 1);
        host_clear(2'b10);
        chk("R7 overrun cleared", 32'(mf_overrun), 0);
        chk("R6 ready unaffected by overrun clear", 32'(mf_ready), 1);
        host_clear(2'b01);

        // R6/R7: clear on the publication edge
        send_range(0, 15);
        send_range(0, 14);
        @(negedge clk);
        ts0_valid = 1; frame_idx = 4'd15; ts0_byte = 8'($urandom);
        @(negedge clk);
        ts0_valid = 0; host_clr_wr = 1; host_clr_mask = 2'b01;
        @(negedge clk);
        host_clr_wr = 0; host_clr_mask = 0;
        chk("R6 publication wins over clear", 32'(mf_ready), 1);
        chk("R7 no overrun when cleared same cycle", 32'(mf_overrun), 0);
        host_clear(2'b11);

        // R8: loss in the middle
        send_range(0, 7);
        @(negedge clk); mf_lost = 1;
        @(negedge clk); mf_lost = 0;
        send_range(8, 15);
        chk("R8 no publication after mid loss", 32'(mf_ready), 0);
        // R8: loss in the commit cycle
        send_range(0, 14);
        send_frame(15, 8'hA5, 0, 1);
        chk("R8 commit suppressed", 32'(mf_ready), 0);
        send_range(0, 15);
        chk("R8 recovery at next frame 0", 32'(mf_ready), 1);
        host_clear(2'b01);

        // R9: skipped frame, then restart at frame 0
        send_range(0, 8);
        send_range(10, 15);
        chk("R9 skipped frame no publication", 32'(mf_ready), 0);
        send_range(0, 5);
        send_range(0, 15);
        chk("R9 restart publishes", 32'(mf_ready), 1);
        sweep = 0;
        for (int a = 0; a < 8; a++) read_chk(a, m_vis[a], "R9 restarted contents");

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog act timeout exp finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule